// File: doc/BRIEF.md
# Holdover Exit Frequency Ramp

When a synchronizer loop has been running on a stored holdover frequency and a valid input returns, the output frequency should not jump to the new value. This block moves the output frequency word from the holdover value to the new target in a straight line. The slope is fixed and chosen from a table of rates. Because the block keeps count of the distance still to go, the ramp always ends exactly on the target, however large the difference is.

A single `start` pulse captures the holdover word, the target word and the rate index. On each `tick` after that, the block adds one signed increment to the output word. The final tick clamps the output onto the target, drops `busy` and raises `done` for one cycle. The slope comes only from the rate index. Nothing related to loop bandwidth enters the block. Loop filtering and phase alignment are handled elsewhere.

Top module: `hold_exit_ramp`

## Requirements
- R1: After reset, `freq_out` is 0 and both `busy` and `done` are 0.
- R2: A `start` while idle with `hold_freq` different from `tgt_freq` makes `busy` 1 and `freq_out` equal to the captured `hold_freq` in the next cycle.
- R3: While busy, a cycle with `tick` high moves `freq_out` by exactly one increment toward the captured target. A cycle without `tick` leaves `freq_out` and `busy` unchanged.
- R4: The increment for rate index i (0 to 39) is (4 + (i mod 4)) * 2^(i div 4) LSBs. Any index above 39 selects index 20, the default setting. The sign of the increment is that of target minus holdover, with both words treated as unsigned.
- R5: When the remaining distance is no larger than the increment, the next tick sets `freq_out` to the target, clears `busy` and raises `done` in the same cycle. A ramp therefore takes ceil(|target - holdover| / increment) ticks.
- R6: A `start` while idle with equal holdover and target words gives `freq_out` = target and `done` = 1 in the next cycle, and `busy` stays 0.
- R7: While busy, `start` and any change on `hold_freq`, `tgt_freq` or `rate_sel` have no effect on the ramp.
- R8: `done` lasts one cycle unless a new start is accepted. After `done`, `freq_out` holds the target until the next accepted start.
- R9: While busy, `freq_out` never passes the captured target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a ramp (ignored while busy) |
| hold_freq | input | W | Holdover frequency word |
| tgt_freq | input | W | New target frequency word |
| rate_sel | input | IDXW | Ramp rate index |
| tick | input | 1 | Update strobe; one step per high cycle |
| freq_out | output | W | Current output frequency word |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse when the target is reached |

## Verification
The assertions assume that the frequency words and the rate index are known whenever `start` is high. They also assume that `tick` can follow any pattern, including long gaps. The random stimulus only draws differences small enough, relative to the increment, for every ramp to finish in a few thousand ticks. It varies the tick density between ramps and, during some ramps, toggles `start` and scrambles the word and rate inputs. Directed cases cover equal words, a remainder-only final step, a landing near zero, the fastest rate and an out-of-range index.

// File: rtl/hold_exit_ramp.sv
module hold_exit_ramp #(
  parameter int W       = 32,
  parameter int NRATES  = 40,
  parameter int IDXW    = $clog2(NRATES),
  parameter int DEF_IDX = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    hold_freq,
  input  logic [W-1:0]    tgt_freq,
  input  logic [IDXW-1:0] rate_sel,
  input  logic            tick,
  output logic [W-1:0]    freq_out,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NRATES - 1);
  localparam logic [IDXW-1:0] DEF_SEL  = IDXW'(DEF_IDX);

  function automatic logic [W-1:0] step_of(input logic [IDXW-1:0] i);
    logic [IDXW-1:0] j;
    j = (i > LAST_IDX) ? DEF_SEL : i;
    return ({{(W-3){1'b0}}, 3'd4} + {{(W-2){1'b0}}, j[1:0]}) << (j >> 2);
  endfunction

  logic [W-1:0] cur_q, tgt_q, rem_q, step_q;
  logic         up_q, busy_q, done_q;

  logic         accept, up_in, last;
  logic [W-1:0] mag_in, next_cur;

  assign accept   = start && !busy_q;
  assign up_in    = tgt_freq > hold_freq;
  assign mag_in   = up_in ? tgt_freq - hold_freq : hold_freq - tgt_freq;
  assign last     = rem_q <= step_q;
  assign next_cur = up_q ? cur_q + step_q : cur_q - step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tgt_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      up_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        tgt_q  <= tgt_freq;
        step_q <= step_of(rate_sel);
        up_q   <= up_in;
        rem_q  <= mag_in;
        if (mag_in == '0) begin
          cur_q  <= tgt_freq;
          done_q <= 1'b1;
        end else begin
          cur_q  <= hold_freq;
          busy_q <= 1'b1;
        end
      end else if (busy_q && tick) begin
        if (last) begin
          cur_q  <= tgt_q;
          rem_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_q  <= next_cur;
          rem_q  <= rem_q - step_q;
        end
      end
    end
  end

  assign freq_out = cur_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/hold_exit_ramp_chk.sv
module hold_exit_ramp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         tick,
  input logic [W-1:0] hold_freq,
  input logic [W-1:0] tgt_freq,
  input logic [W-1:0] freq_out,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] tgt_q,
  input logic         up_q
);
  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && hold_freq != tgt_freq) |=> (busy && freq_out == $past(hold_freq)));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(freq_out)));

  assert_done_on_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && freq_out == tgt_q));

  assert_zero_diff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && hold_freq == tgt_freq) |=> (done && !busy && freq_out == $past(tgt_freq)));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt_q));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && $stable(freq_out)));

  assert_no_overshoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (up_q ? freq_out <= tgt_q : freq_out >= tgt_q));
endmodule

bind hold_exit_ramp hold_exit_ramp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
  .hold_freq(hold_freq), .tgt_freq(tgt_freq), .freq_out(freq_out),
  .busy(busy), .done(done), .tgt_q(tgt_q), .up_q(up_q)
);

// File: tb/hold_exit_ramp_test.sv
module hold_exit_ramp_test;
  localparam int W = 32;
  localparam int IDXW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, start, tick;
  logic [W-1:0]    hold_freq, tgt_freq;
  logic [IDXW-1:0] rate_sel;
  logic [W-1:0]    freq_out;
  logic            busy, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  hold_exit_ramp #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_freq(hold_freq),
    .tgt_freq(tgt_freq), .rate_sel(rate_sel), .tick(tick),
    .freq_out(freq_out), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint step_of(input int idx);
    int j = (idx > 39) ? 20 : idx;
    return longint'(4 + j % 4) << (j / 4);
  endfunction

  function automatic longint expect_at(input longint h, input longint t, input int idx, input longint k);
    longint d = (t > h) ? t - h : h - t;
    longint s = step_of(idx);
    if (k * s >= d) return t;
    return (t > h) ? h + k * s : h - k * s;
  endfunction

  task automatic ramp(input longint h, input longint t, input int idx, input int tick_pct, input bit disturb);
    longint d, s, n, k, e;
    bit tk;
    d = (t > h) ? t - h : h - t;
    s = step_of(idx);
    n = (d + s - 1) / s;
    @(negedge clk);
    hold_freq = W'(h); tgt_freq = W'(t); rate_sel = IDXW'(idx); start = 1'b1; tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (d == 0) begin
      check(done == 1'b1, "R6 done", longint'(done), 1);
      check(busy == 1'b0, "R6 busy", longint'(busy), 0);
      check(freq_out == W'(t), "R6 freq", longint'(freq_out), t);
      @(negedge clk);
      check(done == 1'b0, "R8 pulse", longint'(done), 0);
      return;
    end
    check(busy == 1'b1 && done == 1'b0, "R2 busy", longint'(busy), 1);
    check(freq_out == W'(h), "R2 freq", longint'(freq_out), h);
    k = 0;
    while (k < n) begin
      tk = ($urandom % 100) < tick_pct;
      tick = tk;
      if (disturb) begin
        start = 1'($urandom);
        hold_freq = $urandom; tgt_freq = $urandom; rate_sel = IDXW'($urandom);
      end
      @(negedge clk);
      tick = 1'b0; start = 1'b0;
      if (tk) k++;
      e = expect_at(h, t, idx, k);
      check(freq_out == W'(e), disturb ? "R7 freq" : "R3 R4 freq", longint'(freq_out), e);
      if (k == n) begin
        check(done == 1'b1 && busy == 1'b0, "R5 finish", longint'({busy, done}), 1);
      end else begin
        check(busy == 1'b1 && done == 1'b0, "R3 busy", longint'({busy, done}), 2);
      end
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 pulse", longint'({busy, done}), 0);
    check(freq_out == W'(t), "R8 hold", longint'(freq_out), t);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; tick = 1'b0;
    hold_freq = '0; tgt_freq = '0; rate_sel = '0;
    repeat (3) @(negedge clk);
    check(freq_out == '0, "R1 freq", longint'(freq_out), 0);
    check(busy == 1'b0 && done == 1'b0, "R1 flags", longint'({busy, done}), 0);
    rst_n = 1'b1;

    ramp(1000, 1000, 5, 100, 0);
    ramp(100, 110, 0, 100, 0);
    ramp(300, 2, 3, 60, 0);
    ramp(5000000, 5100000, 39, 100, 0);
    ramp(2000000, 1900000, 39, 40, 0);
    ramp(70000, 60000, 45, 100, 0);
    ramp(70000, 80000, 20, 100, 0);
    ramp(40000, 43000, 9, 50, 1);
    ramp(500, 500, 63, 100, 0);

    for (int r = 0; r < 40; r++) begin
      int idx = $urandom_range(0, 47);
      longint h = longint'($urandom_range(0, 32'h0FFF_FFFF)) + 32'h1000_0000;
      longint s = step_of(idx);
      longint d = longint'($urandom_range(0, 600)) * s / 4 + $urandom_range(0, 3);
      longint t = ($urandom % 2) ? h + d : h - d;
      ramp(h, t, idx, $urandom_range(30, 100), (r % 5) == 2);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule